// File: doc/BRIEF.md
# UART Status Flags and Baud Tick Selector

This block holds the error status and the baud clock configuration of a serial port. It watches the receiver and the transmitter for three faults: a bad stop bit, a byte arriving before the previous one was read, and a data write while a transmission is running. Each fault is kept as a sticky flag. Software reads the flags through an 8-bit register and clears them by writing 0. The flags are status only, and the block has no interrupt output.

The same register chooses where the transmit and receive baud ticks come from. Each direction picks one of four external timer-overflow strobes on its own. An optional divide-by-two stage passes only every second selected overflow. The shift registers, the timers and any interrupt logic sit outside the block.

Top module: `uart_stat_baud`

## Requirements
- R1: After reset the register reads 0x00, and both tick outputs are low.
- R2: When `rx_done` is high and `rx_stop` is low, the frame error flag (bit 7) is set. When `rx_done` is high and `rx_stop` is high, the flag is not set.
- R3: The overrun flag (bit 6) is set when `rx_done` arrives while a received byte is still unread. A byte counts as read after a `buf_rd` strobe. The buffer is empty after reset.
- R4: The collision flag (bit 5) is set when `data_wr` is high while `tx_busy` is high. A `data_wr` while `tx_busy` is low leaves the flag clear.
- R5: A flag stays set until a register write puts 0 in its bit. Writing 1 to a flag bit has no effect.
- R6: If a flag's set condition and a write that clears it happen in the same cycle, the flag ends up set.
- R7: Bits 4:0 read back the value last written. Bits 3:2 select the transmit source and bits 1:0 select the receive source. The codes 00, 01, 10 and 11 choose `tmr_ovf[0]`, `tmr_ovf[1]`, `tmr_ovf[2]` and `tmr_ovf[3]`. The two directions are selected independently.
- R8: With bit 4 set to 1, every pulse on the selected source gives a one-cycle tick in the following cycle.
- R9: With bit 4 set to 0, only every second selected pulse gives a tick. The first pulse after reset or after a select change gives no tick.
- R10: Changing a direction's select value resets that direction's divide-by-two phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_ovf | input | 4 | Timer overflow strobes, one per source |
| rx_done | input | 1 | Receiver byte-complete strobe |
| rx_stop | input | 1 | Sampled stop-bit level, valid with rx_done |
| buf_rd | input | 1 | Receive buffer read strobe |
| tx_busy | input | 1 | Transmission in progress |
| data_wr | input | 1 | Transmit data write strobe |
| reg_wr | input | 1 | Status/config register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| tx_tick | output | 1 | Transmit baud tick pulse |
| rx_tick | output | 1 | Receive baud tick pulse |

## Verification
The hardest case to reach is a divider whose phase is half-way when its select changes. The stimulus enables the divide-by-two stage and sends one pulse on the first source, which leaves the phase armed. It then switches the select and pulses the new source. No tick may follow that pulse, and a second pulse on the new source must give one. A stale phase would instead tick on the first pulse.

// File: rtl/uart_sb_pkg.sv
// Package: shared widths and register bit positions for the UART
// status and baud selector. Assumes an 8-bit register.
package uart_sb_pkg;
    localparam int REG_W     = 8;
    localparam int FLAG_CNT  = 3;
    localparam int BIT_FRAME = 7;
    localparam int BIT_OVRN  = 6;
    localparam int BIT_COLL  = 5;
    localparam int BIT_DBL   = 4;
    localparam int TXS_LO    = 2;
    localparam int RXS_LO    = 0;
    localparam int SEL_W     = 2;
endpackage

// File: rtl/uart_sb_sticky.sv
// Module: one sticky status flag. A set input has priority over a clear
// request in the same cycle. Assumes set and clr are one cycle wide.
module uart_sb_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Flag register: set has priority, then clear, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr) |=> q);
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);
endmodule

// File: rtl/uart_sb_tick.sv
// Module: one baud tick path. It picks one of NSRC overflow strobes and
// can pass only every second pulse. The phase clears when the select
// changes. Output is registered, so it lags the strobe by one cycle.
module uart_sb_tick #(
    parameter int NSRC = 4,
    localparam int SW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] ovf,
    input  logic [SW-1:0]   sel,
    input  logic            bypass,
    output logic            tick
);
    logic          pulse;
    logic          phase;
    logic [SW-1:0] sel_last;
    logic          chg;

    // Source mux: the selected overflow strobe.
    always_comb pulse = ovf[sel];
    // Detect a new select value.
    always_comb chg = (sel != sel_last);

    // Phase, last-select and tick registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= 1'b0;
            sel_last <= '0;
            tick     <= 1'b0;
        end else if (chg) begin
            phase    <= 1'b0;
            sel_last <= sel;
            tick     <= 1'b0;
        end else begin
            if (pulse) phase <= ~phase;
            tick <= pulse && (bypass || phase);
        end
    end

    p_tick_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(pulse));
    p_first_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !bypass && !phase && !chg) |=> !tick);
    p_sel_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> !phase);
endmodule

// File: rtl/uart_stat_baud.sv
// Module: UART status flags and baud tick selector (top).
// It holds three sticky error flags and a 5-bit configuration in one
// 8-bit register, and drives the transmit and receive tick paths.
// Assumes all strobes are synchronous to clk and one cycle wide.
module uart_stat_baud
    import uart_sb_pkg::*;
#(
    parameter int NSRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  tmr_ovf,
    input  logic             rx_done,
    input  logic             rx_stop,
    input  logic             buf_rd,
    input  logic             tx_busy,
    input  logic             data_wr,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             tx_tick,
    output logic             rx_tick
);
    localparam int CFG_W = BIT_DBL + 1;

    logic [CFG_W-1:0]    cfg;
    logic                buf_full;
    logic [FLAG_CNT-1:0] fset, fclr, fq;
    logic [1:0]          ticks;

    // Config register: the bits below the flags, written directly.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg <= '0;
        else if (reg_wr) cfg <= reg_wdata[CFG_W-1:0];
    end

    // Receive buffer occupancy: filled by a byte, emptied by a read.
    always_ff @(posedge clk) begin
        if (!rst_n)       buf_full <= 1'b0;
        else if (rx_done) buf_full <= 1'b1;
        else if (buf_rd)  buf_full <= 1'b0;
    end

    // Set conditions (index 2 = frame, 1 = overrun, 0 = collision).
    always_comb begin
        fset[2] = rx_done && !rx_stop;
        fset[1] = rx_done && buf_full && !buf_rd;
        fset[0] = data_wr && tx_busy;
        fclr    = {FLAG_CNT{reg_wr}} & ~reg_wdata[BIT_COLL +: FLAG_CNT];
    end

    genvar gi;
    generate
        for (gi = 0; gi < FLAG_CNT; gi++) begin : g_flag
            uart_sb_sticky u_flag (
                .clk(clk), .rst_n(rst_n),
                .set(fset[gi]), .clr(fclr[gi]), .q(fq[gi])
            );
        end
        for (gi = 0; gi < 2; gi++) begin : g_tick
            uart_sb_tick #(.NSRC(NSRC)) u_tick (
                .clk(clk), .rst_n(rst_n), .ovf(tmr_ovf),
                .sel(cfg[(gi == 0 ? TXS_LO : RXS_LO) +: SEL_W]),
                .bypass(cfg[BIT_DBL]), .tick(ticks[gi])
            );
        end
    endgenerate

    // Read data: flags on top, config below.
    always_comb begin
        reg_rdata = '0;
        reg_rdata[BIT_COLL +: FLAG_CNT] = fq;
        reg_rdata[CFG_W-1:0]            = cfg;
        tx_tick = ticks[0];
        rx_tick = ticks[1];
    end

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (reg_rdata == '0 && !tx_tick && !rx_tick));
    p_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rx_stop) |=> reg_rdata[BIT_FRAME]);
    p_coll_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && tx_busy) |=> reg_rdata[BIT_COLL]);
    p_cfg_rb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> reg_rdata[CFG_W-1:0] == $past(reg_wdata[CFG_W-1:0]));
endmodule

// File: tb/test_uart_stat_baud.sv
module test_uart_stat_baud;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] tmr_ovf = '0;
    logic       rx_done = 0, rx_stop = 1, buf_rd = 0, tx_busy = 0, data_wr = 0;
    logic       reg_wr = 0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       tx_tick, rx_tick;
    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    uart_stat_baud i_uart_stat_baud (
        .clk(clk), .rst_n(rst_n), .tmr_ovf(tmr_ovf), .rx_done(rx_done),
        .rx_stop(rx_stop), .buf_rd(buf_rd), .tx_busy(tx_busy),
        .data_wr(data_wr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tx_tick(tx_tick), .rx_tick(rx_tick)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); reg_wr = 1; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
        repeat (2) @(negedge clk);
    endtask

    // One overflow pulse; returns {tx_tick, rx_tick} in the following cycle.
    task automatic pulse(input int idx, output logic [1:0] t);
        @(negedge clk); tmr_ovf = '0; tmr_ovf[idx] = 1'b1;
        @(negedge clk); tmr_ovf = '0;
        t = {tx_tick, rx_tick};
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 reg", reg_rdata, 8'h00);
        chk("R1 ticks", {6'd0, tx_tick, rx_tick}, 8'h00);
    endtask

    task automatic t_frame;
        @(negedge clk); rx_done = 1; rx_stop = 1;
        @(negedge clk); rx_done = 0; buf_rd = 1;
        @(negedge clk); buf_rd = 0;
        chk("R2 good stop", reg_rdata & 8'h80, 8'h00);
        @(negedge clk); rx_done = 1; rx_stop = 0;
        @(negedge clk); rx_done = 0; rx_stop = 1; buf_rd = 1;
        @(negedge clk); buf_rd = 0;
        chk("R2 bad stop", reg_rdata & 8'h80, 8'h80);
        wr(8'hFF);
        chk("R5 write one keeps", reg_rdata & 8'h80, 8'h80);
        wr(8'h00);
        chk("R5 write zero clears", reg_rdata, 8'h00);
    endtask

    task automatic t_overrun;
        @(negedge clk); rx_done = 1;
        @(negedge clk); rx_done = 0;
        chk("R3 first byte", reg_rdata & 8'h40, 8'h00);
        @(negedge clk); rx_done = 1;
        @(negedge clk); rx_done = 0;
        chk("R3 overrun", reg_rdata & 8'h40, 8'h40);
        repeat (3) @(negedge clk);
        chk("R5 sticky", reg_rdata & 8'h40, 8'h40);
        wr(8'h00);
        @(negedge clk); buf_rd = 1;
        @(negedge clk); buf_rd = 0; rx_done = 1;
        @(negedge clk); rx_done = 0;
        chk("R3 read first", reg_rdata & 8'h40, 8'h00);
        @(negedge clk); buf_rd = 1;
        @(negedge clk); buf_rd = 0;
    endtask

    task automatic t_collision;
        @(negedge clk); data_wr = 1; tx_busy = 0;
        @(negedge clk); data_wr = 0;
        chk("R4 idle write", reg_rdata & 8'h20, 8'h00);
        @(negedge clk); data_wr = 1; tx_busy = 1; reg_wr = 1; reg_wdata = 8'h00;
        @(negedge clk); data_wr = 0; tx_busy = 0; reg_wr = 0;
        chk("R6 set beats clear", reg_rdata & 8'h20, 8'h20);
        chk("R4 busy write", reg_rdata & 8'h20, 8'h20);
        wr(8'h00);
    endtask

    task automatic t_select;
        logic [1:0] t;
        wr(8'h19); // bypass, tx sel 10, rx sel 01
        chk("R7 readback", reg_rdata, 8'h19);
        pulse(2, t); chk("R7 tx src", {6'd0, t}, 8'h02);
        pulse(1, t); chk("R7 rx src", {6'd0, t}, 8'h01);
        pulse(0, t); chk("R7 unselected", {6'd0, t}, 8'h00);
        wr(8'h1F);
        pulse(3, t); chk("R8 both each", {6'd0, t}, 8'h03);
        pulse(3, t); chk("R8 both again", {6'd0, t}, 8'h03);
    endtask

    task automatic t_divide;
        logic [1:0] t;
        wr(8'h00);
        pulse(0, t); chk("R9 first none", {6'd0, t}, 8'h00);
        pulse(0, t); chk("R9 second tick", {6'd0, t}, 8'h03);
        pulse(0, t); chk("R9 third none", {6'd0, t}, 8'h00);
        wr(8'h05); // both select 01; phase was armed
        pulse(1, t); chk("R10 phase cleared", {6'd0, t}, 8'h00);
        pulse(1, t); chk("R10 then tick", {6'd0, t}, 8'h03);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_frame();
        t_overrun();
        t_collision();
        t_select();
        t_divide();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule